// File: doc/BRIEF.md
# Masked Packed Population Counter

The block treats a vector operand as a row of equal-width lanes (bytes or halfwords) and replaces every lane with the number of 1 bits it holds. The count is zero-extended to the full lane width. A writemask with one bit per lane decides lane by lane whether the count is kept. When a lane's bit is 0, a fallback value is used instead. In zeroing mode the fallback is zero. In merging mode it is the lane at the same position in a second source vector.

A mask-enable input turns masking off, so that every lane takes its count. Results are registered once. A valid strobe goes in with the operands and comes back out one cycle later. The vector width (128, 256 or 512) and the lane width (8 or 16) are parameters.

Top module: `vpc_top`

## Requirements
- R1: Each result lane holds the number of 1 bits in the matching input lane, zero-extended to the lane width.
- R2: Lane i occupies bits [i*ELEM_W +: ELEM_W] of data_i, src_i and result_o, and lanes never interact.
- R3: With mask_en_i=1, a lane whose bit mask_i[i] is 1 receives its count.
- R4: With mask_en_i=1 and zero_mode_i=1, a lane whose mask bit is 0 outputs all zeros.
- R5: With mask_en_i=1 and zero_mode_i=0, a lane whose mask bit is 0 outputs the matching src_i lane unchanged.
- R6: With mask_en_i=0, every lane receives its count whatever mask_i and zero_mode_i hold.
- R7: Mask bits at positions VEC_W/ELEM_W and above have no effect on result_o.
- R8: out_valid_o is 1 in the cycle after a cycle with in_valid_i=1, and 0 after a cycle with in_valid_i=0.
- R9: result_o keeps its value through any cycle in which in_valid_i is 0.
- R10: While rst_ni is low, out_valid_o and result_o are 0.
- R11: An all-ones lane yields ELEM_W, a lane with a single set bit yields 1, and a zero lane yields 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands are valid this cycle |
| mask_en_i | input | 1 | 1: apply mask_i; 0: count every lane |
| zero_mode_i | input | 1 | 1: masked-off lanes become zero; 0: masked-off lanes take src_i |
| mask_i | input | MASK_W (64) | Per-lane writemask; bit i governs lane i |
| data_i | input | VEC_W | Vector whose lanes are counted |
| src_i | input | VEC_W | Merge source vector |
| out_valid_o | output | 1 | result_o carries a new result |
| result_o | output | VEC_W | Registered per-lane result |

## Verification
Every result and out_valid_o is due exactly one rising edge after the cycle in which in_valid_i was sampled high. The bench changes inputs on the falling edge and holds in_valid_i for one cycle. It then reads result_o and out_valid_o at the next falling edge, which is the first point after the loading edge at which both are settled. The hold and valid-drop checks are made on the falling edges that follow, with in_valid_i held low, so each check sees one known edge.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic {
    FILL_MERGE = 1'b0,
    FILL_ZERO  = 1'b1
  } fill_e;

  function automatic int cnt_width(input int elem_w);
    return $clog2(elem_w + 1);
  endfunction
endpackage

// File: rtl/vpc_lane_count.sv
// Adder tree over one lane, heap-indexed: leaves at [ELEM_W, 2*ELEM_W-1], root at 1.
module vpc_lane_count #(
  parameter int ELEM_W = 8,
  parameter int CNT_W  = vpc_pkg::cnt_width(ELEM_W)
) (
  input  logic [ELEM_W-1:0] elem_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int NODES = 2 * ELEM_W;

  logic [CNT_W-1:0] node [1:NODES-1];

  for (genvar j = 0; j < ELEM_W; j++) begin : g_leaf
    assign node[ELEM_W + j] = CNT_W'(elem_i[j]);
  end

  for (genvar k = 1; k < ELEM_W; k++) begin : g_sum
    assign node[k] = node[2*k] + node[2*k+1];
  end

  assign cnt_o = node[1];
endmodule

// File: rtl/vpc_lane_mux.sv
module vpc_lane_mux #(
  parameter int ELEM_W = 8,
  parameter int CNT_W  = vpc_pkg::cnt_width(ELEM_W)
) (
  input  logic              keep_i,
  input  vpc_pkg::fill_e    fill_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ELEM_W-1:0] src_i,
  output logic [ELEM_W-1:0] lane_o
);
  always_comb begin
    if (keep_i)                            lane_o = ELEM_W'(cnt_i);
    else if (fill_i == vpc_pkg::FILL_ZERO) lane_o = '0;
    else                                   lane_o = src_i;
  end
endmodule

// File: rtl/vpc_top.sv
module vpc_top #(
  parameter int VEC_W  = 128,
  parameter int ELEM_W = 8,
  parameter int MASK_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              mask_en_i,
  input  logic              zero_mode_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [VEC_W-1:0]  data_i,
  input  logic [VEC_W-1:0]  src_i,
  output logic              out_valid_o,
  output logic [VEC_W-1:0]  result_o
);
  import vpc_pkg::*;

  localparam int LANES = VEC_W / ELEM_W;
  localparam int CNT_W = cnt_width(ELEM_W);

  fill_e             fill;
  logic [LANES-1:0]  keep;
  logic [VEC_W-1:0]  result_d;

  assign fill = fill_e'(zero_mode_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CNT_W-1:0] cnt;

    assign keep[l] = mask_i[l] | ~mask_en_i;

    vpc_lane_count #(.ELEM_W(ELEM_W), .CNT_W(CNT_W)) u_cnt (
      .elem_i (data_i[l*ELEM_W +: ELEM_W]),
      .cnt_o  (cnt)
    );

    vpc_lane_mux #(.ELEM_W(ELEM_W), .CNT_W(CNT_W)) u_mux (
      .keep_i (keep[l]),
      .fill_i (fill),
      .cnt_i  (cnt),
      .src_i  (src_i[l*ELEM_W +: ELEM_W]),
      .lane_o (result_d[l*ELEM_W +: ELEM_W])
    );

    // R5
    merge_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && mask_en_i && !mask_i[l] && !zero_mode_i)
        |=> result_o[l*ELEM_W +: ELEM_W] == $past(src_i[l*ELEM_W +: ELEM_W]));

    // R4
    zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && mask_en_i && !mask_i[l] && zero_mode_i)
        |=> result_o[l*ELEM_W +: ELEM_W] == '0);

    // R1
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && (mask_i[l] || !mask_en_i))
        |=> result_o[l*ELEM_W +: ELEM_W] <= ELEM_W'(ELEM_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= result_d;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  // R8
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
endmodule

// File: tb/tb_vpc_top.sv
`timescale 1ns/1ps
module tb_vpc_top;
  localparam int VEC_W  = 128;
  localparam int ELEM_W = 8;
  localparam int MASK_W = 64;
  localparam int LANES  = VEC_W / ELEM_W;
  localparam int NV     = 6;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid = 1'b0;
  logic              mask_en = 1'b0;
  logic              zero_mode = 1'b0;
  logic [MASK_W-1:0] mask = '0;
  logic [VEC_W-1:0]  data = '0;
  logic [VEC_W-1:0]  src = '0;
  logic              out_valid;
  logic [VEC_W-1:0]  result;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  vpc_top #(.VEC_W(VEC_W), .ELEM_W(ELEM_W), .MASK_W(MASK_W)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .in_valid_i (in_valid),
    .mask_en_i (mask_en), .zero_mode_i (zero_mode), .mask_i (mask),
    .data_i (data), .src_i (src), .out_valid_o (out_valid), .result_o (result)
  );

  localparam logic [VEC_W-1:0] TV_DATA [NV] = '{
    128'h00010307_0F1F3F7F_FF020408_10204080,
    128'hABCE64D9_6DFDBEB1_FEB3D7E6_44C9ACB7,
    128'hABCE64D9_6DFDBEB1_FEB3D7E6_44C9ACB7,
    128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
    128'h9A5438E3_BD8C2375_DBA9E2AA_0D169FFB,
    128'h49798F91_555B895A_E115F9D3_9BE44680
  };
  localparam logic [VEC_W-1:0] TV_SRC [NV] = '{
    128'h0, 128'h0,
    128'h11223344_55667788_99AABBCC_DDEEFF00,
    128'hCAFEF00D_DEADBEEF_01234567_89ABCDEF,
    128'h55555555_55555555_55555555_55555555,
    128'h0F0E0D0C_0B0A0908_07060504_03020100
  };
  localparam logic [MASK_W-1:0] TV_MASK [NV] = '{
    64'h0, 64'hF0F0, 64'h0F0F, 64'h0, 64'h0, 64'hFFFF
  };
  localparam logic [NV-1:0] TV_MEN  = 6'b110110; // bit v = entry v
  localparam logic [NV-1:0] TV_ZERO = 6'b010010;
  string tv_tag [NV] = '{"R1/R2", "R3/R4", "R5", "R6", "R4", "R3"};

  function automatic logic [VEC_W-1:0] model(input logic [VEC_W-1:0] d, s,
      input logic [MASK_W-1:0] m, input logic zm, men);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) begin
      int c;
      c = 0;
      for (int b = 0; b < ELEM_W; b++) c += int'(d[l*ELEM_W + b]);
      if (!men || m[l]) r[l*ELEM_W +: ELEM_W] = ELEM_W'(c);
      else if (zm)      r[l*ELEM_W +: ELEM_W] = '0;
      else              r[l*ELEM_W +: ELEM_W] = s[l*ELEM_W +: ELEM_W];
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [VEC_W-1:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [VEC_W-1:0] d, s, input logic [MASK_W-1:0] m,
                       input logic zm, men);
    @(negedge clk);
    data = d; src = s; mask = m; zero_mode = zm; mask_en = men; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VEC_W-1:0] exp, held;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid", VEC_W'(out_valid), '0);
    chk(result == '0, "R10 result", result, '0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      issue(TV_DATA[v], TV_SRC[v], TV_MASK[v], TV_ZERO[v], TV_MEN[v]);
      exp = model(TV_DATA[v], TV_SRC[v], TV_MASK[v], TV_ZERO[v], TV_MEN[v]);
      chk(result == exp, tv_tag[v], result, exp);
      chk(out_valid == 1'b1, "R8 valid", VEC_W'(out_valid), 1);
    end

    // R9 and R8: hold with valid low
    held = result;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 drop", VEC_W'(out_valid), 0);
    data = ~data; src = ~src; mask = ~mask;
    repeat (3) @(negedge clk);
    chk(result == held, "R9 hold", result, held);

    // R7: bits above lane count ignored
    issue(TV_DATA[4], TV_SRC[4], 64'hFFFF_FFFF_FFFF_00FF, 1'b1, 1'b1);
    exp = model(TV_DATA[4], TV_SRC[4], 64'h00FF, 1'b1, 1'b1);
    chk(result == exp, "R7 zero", result, exp);
    issue(TV_DATA[5], TV_SRC[5], 64'hAAAA_0000_0000_0000, 1'b0, 1'b1);
    chk(result == TV_SRC[5], "R7 merge", result, TV_SRC[5]);

    // R11: extremes
    issue({VEC_W{1'b1}}, '0, '0, 1'b0, 1'b0);
    chk(result == {LANES{8'h08}}, "R11 all-ones", result, {LANES{8'h08}});
    issue({2{64'h8040_2010_0804_0201}}, '0, 64'hFFFF, 1'b1, 1'b1);
    chk(result == {LANES{8'h01}}, "R11 single", result, {LANES{8'h01}});
    issue('0, {VEC_W{1'b1}}, 64'hFFFF, 1'b0, 1'b1);
    chk(result == '0, "R11 zero", result, '0);

    // R10: reset mid-run clears outputs
    issue({VEC_W{1'b1}}, '0, '0, 1'b0, 1'b0);
    rst_ni = 1'b0;
    #1;
    chk(result == '0, "R10 async result", result, '0);
    chk(out_valid == 1'b0, "R10 async valid", VEC_W'(out_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule